// File: doc/BRIEF.md
# Dadda Column-Reduction Multiplier

This is a purely combinational multiplier. It takes two operands of the same width N and returns their full product of 2N bits. A parameter picks the number format. In unsigned mode the operands are plain binary. In signed mode they are two's complement, and the partial-product matrix is built in Baugh-Wooley form.

The block first forms every partial-product bit and drops each one into the column of its weight. It then shrinks the columns in stages. Each stage has a target height taken from the Dadda series 2, 3, 4, 6, 9, 13, 19, 28, where each term is the floor of 1.5 times the one before. Reduction starts at the largest term below N and ends at 2. Within a stage the columns are visited from least to most significant:

- A column exactly one bit over the target gets a half adder on its top two bits.
- A column two or more bits over the target gets a full adder on its top three bits, and the same column is examined again.
- Each sum bit goes to the bottom of its own column.
- Each carry bit goes to the top of the next column.

Once every column holds at most two bits, a ripple-carry adder forms the product. Product bit 0 is the lone a0·b0 term.

Top module: `dadda_mult`

## Requirements
- R1: In unsigned mode (SIGNED=0), prod equals op_a times op_b, with both operands read as unsigned binary, for every operand pair.
- R2: In signed mode (SIGNED=1), the operands are two's complement and prod is the exact product as a 2N-bit two's-complement value. For example, with N=8, 8'h80 times 8'h80 gives 16'h4000 and 8'h80 times 8'h7F gives 16'hC080.
- R3: With N=1, prod[0] is op_a[0] AND op_b[0] and prod[1] is 0, in both modes.
- R4: prod[0] always equals op_a[0] AND op_b[0].
- R5: If either operand is zero, prod is zero in both modes.
- R6: If op_b is one, prod equals op_a. In unsigned mode op_a is zero-extended. In signed mode with N>1 it is sign-extended.
- R7: Swapping the two operands leaves prod unchanged.
- R8: With N=2 no reduction stage runs, and the final adder over columns 1 to 3 gives the product. In signed mode the constant bit in column 2 is counted, so all 16 operand pairs give the exact product in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Multiplicand, unsigned or two's complement according to SIGNED |
| op_b | input | N | Multiplier, same format as op_a |
| prod | output | 2N | Full-width product |

## Verification
The bench checks every operand pair for widths 1, 2, 3, 4 and 6. These widths cover no reduction stage, one stage, and the two- and three-stage schedules. A reduction that keeps a column at three bits would drop a carry and give wrong high bits.

The most negative operand in signed mode exercises the NAND-inverted border rows and the constant bit in column N. A design that left out the constant or the final MSB flip would be off by 2^N or 2^(2N-1).

The N=2 signed case catches a final adder that ignores the second bit of column 2. That fault makes 0 times 0 come out as a negative value.

Unit and zero operands, together with operand swapping, catch asymmetric partial-product wiring and wrong extension of the result.

// File: rtl/dadda_mult.sv
`timescale 1ns/1ps
module dadda_mult #(
  parameter int N      = 8,
  parameter bit SIGNED = 1'b0
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);

  localparam int W      = 2 * N;
  localparam int H      = 2 * N + 2;
  localparam int MAXSTG = 16;
  localparam bit FLIP   = SIGNED && (N > 1);

  // largest term of the 2,3,4,6,9,... series strictly below w (0 if none)
  function automatic int below_height(input int w);
    int t;
    int nx;
    t  = 0;
    nx = 2;
    while (nx < w) begin
      t  = nx;
      nx = (nx * 3) / 2;
    end
    return t;
  endfunction

  localparam int FIRST_D = below_height(N);

  logic [W-1:0] fin_x;
  logic [W-1:0] fin_y;

  always_comb begin : reduce
    logic col_bit [W][H];
    int   col_ht  [W];
    int   tgt;
    logic pp, bx, by, bz, sm, cy;

    for (int c = 0; c < W; c++) begin
      col_ht[c] = 0;
      for (int r = 0; r < H; r++) col_bit[c][r] = 1'b0;
    end
    pp = 1'b0; bx = 1'b0; by = 1'b0; bz = 1'b0; sm = 1'b0; cy = 1'b0;

    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        pp = op_a[i] & op_b[j];
        if (SIGNED && ((i == N - 1) != (j == N - 1))) pp = ~pp;
        col_bit[i+j][col_ht[i+j]] = pp;
        col_ht[i+j] = col_ht[i+j] + 1;
      end
    end

    if (FLIP) begin
      for (int r = H - 1; r > 1; r--) col_bit[N][r] = col_bit[N][r-1];
      col_bit[N][1] = 1'b1;
      col_ht[N] = col_ht[N] + 1;
    end

    tgt = FIRST_D;
    for (int s = 0; s < MAXSTG; s++) begin
      if (tgt >= 2) begin
        for (int c = 0; c < W; c++) begin
          for (int k = 0; k < H; k++) begin
            if (col_ht[c] == tgt + 1) begin
              bx = col_bit[c][0];
              by = col_bit[c][1];
              sm = bx ^ by;
              cy = bx & by;
              for (int r = 0; r < H - 2; r++) col_bit[c][r] = col_bit[c][r+2];
              col_ht[c] = col_ht[c] - 2;
              col_bit[c][col_ht[c]] = sm;
              col_ht[c] = col_ht[c] + 1;
              if (c < W - 1) begin
                for (int r = H - 1; r > 0; r--) col_bit[c+1][r] = col_bit[c+1][r-1];
                col_bit[c+1][0] = cy;
                col_ht[c+1] = col_ht[c+1] + 1;
              end
            end else if (col_ht[c] > tgt + 1) begin
              bx = col_bit[c][0];
              by = col_bit[c][1];
              bz = col_bit[c][2];
              sm = bx ^ by ^ bz;
              cy = (bx & by) | (bz & (bx ^ by));
              for (int r = 0; r < H - 3; r++) col_bit[c][r] = col_bit[c][r+3];
              col_ht[c] = col_ht[c] - 3;
              col_bit[c][col_ht[c]] = sm;
              col_ht[c] = col_ht[c] + 1;
              if (c < W - 1) begin
                for (int r = H - 1; r > 0; r--) col_bit[c+1][r] = col_bit[c+1][r-1];
                col_bit[c+1][0] = cy;
                col_ht[c+1] = col_ht[c+1] + 1;
              end
            end
          end
        end
        tgt = below_height(tgt);
      end
    end

    for (int c = 0; c < W; c++) begin
      fin_x[c] = (col_ht[c] > 0) ? col_bit[c][0] : 1'b0;
      fin_y[c] = (col_ht[c] > 1) ? col_bit[c][1] : 1'b0;
    end
  end

  logic [W-1:0] rsum;
  logic [W-1:0] rcar;

  assign rcar[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_rip
    assign rsum[k] = fin_x[k] ^ fin_y[k] ^ rcar[k];
    if (k < W - 1) begin : g_cy
      assign rcar[k+1] = (fin_x[k] & fin_y[k]) | (rcar[k] & (fin_x[k] ^ fin_y[k]));
    end
  end

  assign prod = {rsum[W-1] ^ FLIP, rsum[W-2:0]};

endmodule

// File: rtl/dadda_mult_chk.sv
`timescale 1ns/1ps
module dadda_mult_chk #(
  parameter int N      = 8,
  parameter bit SIGNED = 1'b0
) (
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod
);

  localparam int W = 2 * N;

  logic [W-1:0] ext_a;
  logic [W-1:0] ext_b;
  logic [W-1:0] ref_p;

  always_comb begin
    ext_a = {{N{SIGNED & op_a[N-1]}}, op_a};
    ext_b = {{N{SIGNED & op_b[N-1]}}, op_b};
    ref_p = ext_a * ext_b;
  end

  always_comb begin
    // R1, R2
    prod_match_chk: assert (prod == ref_p)
      else $error("product %h differs from %h", prod, ref_p);
    // R4
    lsb_chk: assert (prod[0] == (op_a[0] & op_b[0]))
      else $error("product bit 0 wrong");
    // R5
    if (op_a == '0 || op_b == '0)
      zero_chk: assert (prod == '0) else $error("zero operand gave %h", prod);
    // R6
    if (op_b == N'(1) && (!SIGNED || N > 1))
      unit_chk: assert (prod == ext_a) else $error("unit operand gave %h", prod);
    // R3
    if (N == 1)
      narrow_chk: assert (prod[W-1] == 1'b0) else $error("upper bit set at width 1");
  end

endmodule

bind dadda_mult dadda_mult_chk #(.N(N), .SIGNED(SIGNED)) u_chk (
  .op_a(op_a),
  .op_b(op_b),
  .prod(prod)
);

// File: tb/dadda_mult_tb_top.sv
`timescale 1ns/1ps
module dadda_mult_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  logic [4:0] done = '0;

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // exhaustive sweeps at small widths, both modes
  localparam int SZ [5] = '{1, 2, 3, 4, 6};

  for (genvar g = 0; g < 5; g++) begin : g_ex
    localparam int NG = SZ[g];
    logic [NG-1:0]   ea, eb;
    logic [2*NG-1:0] pu, ps;

    dadda_mult #(.N(NG), .SIGNED(1'b0)) dut_u_i (.op_a(ea), .op_b(eb), .prod(pu));
    dadda_mult #(.N(NG), .SIGNED(1'b1)) dut_s_i (.op_a(ea), .op_b(eb), .prod(ps));

    initial begin
      ea = '0;
      eb = '0;
      @(negedge clk);
      for (int x = 0; x < (1 << NG); x++) begin
        for (int y = 0; y < (1 << NG); y++) begin
          int sx, sy, msk;
          @(posedge clk);
          ea = NG'(x);
          eb = NG'(y);
          @(negedge clk);
          msk = (1 << (2 * NG)) - 1;
          sx = (x >= (1 << (NG - 1))) ? x - (1 << NG) : x;
          sy = (y >= (1 << (NG - 1))) ? y - (1 << NG) : y;
          check(NG == 1 ? "R3" : (NG == 2 ? "R8" : "R1"), "unsigned sweep",
                16'(pu), 16'((x * y) & msk));
          check(NG == 1 ? "R3" : (NG == 2 ? "R8" : "R2"), "signed sweep",
                16'(ps), 16'((sx * sy) & msk));
          check("R4", "bit0", 16'(ps[0]), 16'(x & y & 1));
        end
      end
      done[g] = 1'b1;
    end
  end

  // width 8 main instances
  logic [7:0]  a8 = '0;
  logic [7:0]  b8 = '0;
  logic [15:0] pu8, ps8;

  dadda_mult #(.N(8), .SIGNED(1'b0)) dut_i   (.op_a(a8), .op_b(b8), .prod(pu8));
  dadda_mult #(.N(8), .SIGNED(1'b1)) dut_s_i (.op_a(a8), .op_b(b8), .prod(ps8));

  // {a, b, unsigned product, signed product}
  localparam logic [47:0] TBL [13] = '{
    {8'h00, 8'h00, 16'h0000, 16'h0000},
    {8'hFF, 8'hFF, 16'hFE01, 16'h0001},
    {8'h80, 8'h80, 16'h4000, 16'h4000},
    {8'h80, 8'h7F, 16'h3F80, 16'hC080},
    {8'h7F, 8'h7F, 16'h3F01, 16'h3F01},
    {8'hFF, 8'h01, 16'h00FF, 16'hFFFF},
    {8'h80, 8'h01, 16'h0080, 16'hFF80},
    {8'h80, 8'hFF, 16'h7F80, 16'h0080},
    {8'h12, 8'h34, 16'h03A8, 16'h03A8},
    {8'hAB, 8'hCD, 16'h88EF, 16'h10EF},
    {8'h01, 8'h00, 16'h0000, 16'h0000},
    {8'h55, 8'hAA, 16'h3872, 16'hE372},
    {8'hFE, 8'h03, 16'h02FA, 16'hFFFA}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    @(negedge clk);
    // R5: idle operands at start give zero
    check("R5", "initial unsigned", pu8, 16'h0000);
    check("R5", "initial signed", ps8, 16'h0000);

    for (int t = 0; t < 13; t++) begin
      @(posedge clk);
      a8 = TBL[t][47:40];
      b8 = TBL[t][39:32];
      @(negedge clk);
      check("R1", "table unsigned", pu8, TBL[t][31:16]);
      check("R2", "table signed", ps8, TBL[t][15:0]);
    end

    for (int x = 0; x < 256; x++) begin
      @(posedge clk);
      a8 = 8'(x);
      b8 = 8'h00;
      @(negedge clk);
      check("R5", "b zero unsigned", pu8, 16'h0000);
      check("R5", "b zero signed", ps8, 16'h0000);
      @(posedge clk);
      a8 = 8'h00;
      b8 = 8'(x);
      @(negedge clk);
      check("R5", "a zero signed", ps8, 16'h0000);
      @(posedge clk);
      a8 = 8'(x);
      b8 = 8'h01;
      @(negedge clk);
      check("R6", "unit unsigned", pu8, {8'h00, 8'(x)});
      check("R6", "unit signed", ps8, {{8{a8[7]}}, 8'(x)});
    end

    for (int t = 0; t < 3000; t++) begin
      logic [7:0]  ra, rb;
      logic [15:0] fu, fs;
      int sa, sb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      sa = int'($signed(ra));
      sb = int'($signed(rb));
      @(posedge clk);
      a8 = ra;
      b8 = rb;
      @(negedge clk);
      fu = pu8;
      fs = ps8;
      check("R1", "random unsigned", fu, 16'({24'd0, ra} * {24'd0, rb}));
      check("R2", "random signed", fs, 16'(sa * sb));
      @(posedge clk);
      a8 = rb;
      b8 = ra;
      @(negedge clk);
      check("R7", "swap unsigned", pu8, fu);
      check("R7", "swap signed", ps8, fs);
    end

    wait (&done);
    @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

endmodule